// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits at the head of an instruction queue and looks at the two oldest decoded entries in each cycle. The older entry, called the lead, always goes to the main pipe, which can execute any instruction. The younger entry, called the trail, may go to the secondary pipe in the same cycle. The secondary pipe runs only simple instructions, so the trail goes there only when every pairing rule holds.

The decision is purely combinational. The block drives one issue strobe for each pipe and a count of how many queue entries were taken. A stall input from downstream holds everything back. The pairing rules are:

- both entries must be simple;
- the lead must not be a branch;
- the lead's destination must not be a source the trail reads;
- the lead's destination must not be the trail's destination.

A register comparison counts only when the flags that qualify it are set.

Top module: `pair_issue_check`

## Requirements
- R1: With `stall` low and `i1_valid` low, `issue_main` and `issue_sec` are 0 and `consume` is 0, whatever the other inputs are.
- R2: With `stall` high, `issue_main` and `issue_sec` are 0 and `consume` is 0, whatever the other inputs are.
- R3: With `stall` low, `i1_valid` high and `i2_valid` low, `issue_main` is 1, `issue_sec` is 0 and `consume` is 1. The pairing rules play no part in this case.
- R4: When either `i1_simple` or `i2_simple` is 0, the trail is not issued. The lead still issues alone with `consume` = 1.
- R5: When `i1_branch` is 1, the trail is not issued and `consume` is 1.
- R6: The trail is not issued when `i1_has_dest` is 1 and, for some source k with `i2_src_use[k]` = 1, field k of `i2_src` equals `i1_dest`. Source k occupies bits [k*REG_W +: REG_W]. A source whose use flag is 0 is never compared.
- R7: The trail is not issued when `i1_has_dest` and `i2_has_dest` are both 1 and `i1_dest` equals `i2_dest`. When either flag is 0, the destinations are not compared.
- R8: When both entries are valid, `stall` is low and no rule in R4 to R7 refuses the pair, `issue_main` and `issue_sec` are 1 and `consume` is 2.
- R9: `issue_sec` is never 1 unless `issue_main` is 1, and `consume` always equals the number of issue strobes that are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i1_valid | input | 1 | Lead entry is present |
| i1_simple | input | 1 | Lead is a simple instruction |
| i1_branch | input | 1 | Lead is a branch |
| i1_has_dest | input | 1 | Lead writes a register |
| i1_dest | input | REG_W | Lead destination register |
| i2_valid | input | 1 | Trail entry is present |
| i2_simple | input | 1 | Trail is a simple instruction |
| i2_has_dest | input | 1 | Trail writes a register |
| i2_dest | input | REG_W | Trail destination register |
| i2_src_use | input | NUM_SRC | Per-source read flags of the trail |
| i2_src | input | NUM_SRC*REG_W | Packed trail source registers |
| stall | input | 1 | Downstream hold; no issue this cycle |
| issue_main | output | 1 | Lead goes to the main pipe |
| issue_sec | output | 1 | Trail goes to the secondary pipe |
| consume | output | 2 | Queue entries taken this cycle (0, 1 or 2) |

## Verification
The bench builds the block with its defaults: five-bit register numbers and two sources per trail entry. If register numbers were drawn across all 32 values, a match would come up only about once in 32 draws. The random stimulus therefore draws them from a pool of four. This makes read and write overlaps common, and each overlap shows up both with its qualifying flag set and with it cleared. Directed vectors add the cases where a match sits in the second source field alone and where several refusal reasons apply together.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int unsigned CNT_W = 2;

  // A qualified register match: both sides must be enabled and equal.
  function automatic logic reg_hit(input logic en_a, input logic en_b,
                                   input logic [31:0] a, input logic [31:0] b);
    return en_a && en_b && (a == b);
  endfunction

  // Number of issue strobes that are high.
  function automatic logic [CNT_W-1:0] issue_count(input logic m, input logic s);
    return CNT_W'(m) + CNT_W'(s);
  endfunction
endpackage

// File: rtl/pair_hazard.sv
module pair_hazard #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                     ld_has_dest,
  input  logic [REG_W-1:0]         ld_dest,
  input  logic                     tr_has_dest,
  input  logic [REG_W-1:0]         tr_dest,
  input  logic [NUM_SRC-1:0]       tr_src_use,
  input  logic [NUM_SRC*REG_W-1:0] tr_src,
  output logic                     raw_hit,
  output logic                     waw_hit
);
  import pair_pkg::*;

  logic [NUM_SRC-1:0] src_hit;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign src_hit[k] = reg_hit(ld_has_dest, tr_src_use[k],
                                32'(ld_dest), 32'(tr_src[k*REG_W +: REG_W]));
  end

  assign raw_hit = |src_hit;
  assign waw_hit = reg_hit(ld_has_dest, tr_has_dest, 32'(ld_dest), 32'(tr_dest));

  always_comb begin
    // R6: no read overlap is reported without a destination on the lead
    p_raw_needs_dest_r6: assert (!raw_hit || ld_has_dest);
    // R7: no write overlap is reported unless both sides write
    p_waw_needs_dest_r7: assert (!waw_hit || (ld_has_dest && tr_has_dest));
  end
endmodule

// File: rtl/pair_class.sv
module pair_class (
  input  logic ld_simple,
  input  logic ld_branch,
  input  logic tr_simple,
  output logic class_ok
);
  assign class_ok = ld_simple && tr_simple && !ld_branch;
endmodule

// File: rtl/pair_decide.sv
module pair_decide (
  input  logic       ld_valid,
  input  logic       tr_valid,
  input  logic       stall,
  input  logic       class_ok,
  input  logic       raw_hit,
  input  logic       waw_hit,
  input  logic       ld_simple,
  input  logic       tr_simple,
  input  logic       ld_branch,
  output logic       issue_main,
  output logic       issue_sec,
  output logic [1:0] consume
);
  import pair_pkg::*;

  logic go_main;
  logic pair_ok;

  assign go_main    = ld_valid && !stall;
  assign pair_ok    = class_ok && !raw_hit && !waw_hit;
  assign issue_main = go_main;
  assign issue_sec  = go_main && tr_valid && pair_ok;
  assign consume    = issue_count(issue_main, issue_sec);

  always_comb begin
    p_empty_r1:      assert (ld_valid || stall || consume == 2'd0);
    p_stall_r2:      assert (!stall || (!issue_main && !issue_sec));
    p_single_r3:     assert (!(go_main && !tr_valid) || (issue_main && !issue_sec));
    p_simple_r4:     assert ((ld_simple && tr_simple) || !issue_sec);
    p_branch_r5:     assert (!ld_branch || !issue_sec);
    p_raw_r6:        assert (!raw_hit || !issue_sec);
    p_waw_r7:        assert (!waw_hit || !issue_sec);
    p_pair_r8:       assert (!(go_main && tr_valid && pair_ok) || consume == 2'd2);
    p_sec_main_r9:   assert (!issue_sec || issue_main);
  end
endmodule

// File: rtl/pair_issue_check.sv
module pair_issue_check #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                     i1_valid,
  input  logic                     i1_simple,
  input  logic                     i1_branch,
  input  logic                     i1_has_dest,
  input  logic [REG_W-1:0]         i1_dest,
  input  logic                     i2_valid,
  input  logic                     i2_simple,
  input  logic                     i2_has_dest,
  input  logic [REG_W-1:0]         i2_dest,
  input  logic [NUM_SRC-1:0]       i2_src_use,
  input  logic [NUM_SRC*REG_W-1:0] i2_src,
  input  logic                     stall,
  output logic                     issue_main,
  output logic                     issue_sec,
  output logic [1:0]               consume
);
  logic raw_hit;
  logic waw_hit;
  logic class_ok;

  pair_hazard #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_hazard (
    .ld_has_dest (i1_has_dest),
    .ld_dest     (i1_dest),
    .tr_has_dest (i2_has_dest),
    .tr_dest     (i2_dest),
    .tr_src_use  (i2_src_use),
    .tr_src      (i2_src),
    .raw_hit     (raw_hit),
    .waw_hit     (waw_hit)
  );

  pair_class u_class (
    .ld_simple (i1_simple),
    .ld_branch (i1_branch),
    .tr_simple (i2_simple),
    .class_ok  (class_ok)
  );

  pair_decide u_decide (
    .ld_valid   (i1_valid),
    .tr_valid   (i2_valid),
    .stall      (stall),
    .class_ok   (class_ok),
    .raw_hit    (raw_hit),
    .waw_hit    (waw_hit),
    .ld_simple  (i1_simple),
    .tr_simple  (i2_simple),
    .ld_branch  (i1_branch),
    .issue_main (issue_main),
    .issue_sec  (issue_sec),
    .consume    (consume)
  );
endmodule

// File: tb/test_pair_issue_check.sv
module test_pair_issue_check;
  localparam int REG_W   = 5;
  localparam int NUM_SRC = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic                     i1_valid, i1_simple, i1_branch, i1_has_dest;
  logic [REG_W-1:0]         i1_dest;
  logic                     i2_valid, i2_simple, i2_has_dest;
  logic [REG_W-1:0]         i2_dest;
  logic [NUM_SRC-1:0]       i2_src_use;
  logic [NUM_SRC*REG_W-1:0] i2_src;
  logic                     stall;
  logic                     issue_main, issue_sec;
  logic [1:0]               consume;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  pair_issue_check #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_pair_issue_check (
    .i1_valid(i1_valid), .i1_simple(i1_simple), .i1_branch(i1_branch),
    .i1_has_dest(i1_has_dest), .i1_dest(i1_dest),
    .i2_valid(i2_valid), .i2_simple(i2_simple), .i2_has_dest(i2_has_dest),
    .i2_dest(i2_dest), .i2_src_use(i2_src_use), .i2_src(i2_src),
    .stall(stall), .issue_main(issue_main), .issue_sec(issue_sec),
    .consume(consume)
  );

  // Expected outcome and the requirement that decides it, from the brief.
  function automatic string predict(output logic em, output logic es,
                                    output logic [1:0] ec);
    logic rd_ovl = 1'b0;
    em = 0; es = 0; ec = 0;
    if (stall) return "R2";
    if (!i1_valid) return "R1";
    em = 1; ec = 1;
    if (!i2_valid) return "R3";
    for (int k = 0; k < NUM_SRC; k++)
      if (i1_has_dest && i2_src_use[k] && i2_src[k*REG_W +: REG_W] == i1_dest)
        rd_ovl = 1'b1;
    if (!(i1_simple && i2_simple)) return "R4";
    if (i1_branch) return "R5";
    if (rd_ovl) return "R6";
    if (i1_has_dest && i2_has_dest && i1_dest == i2_dest) return "R7";
    es = 1; ec = 2;
    return "R8";
  endfunction

  task automatic check_now();
    logic em, es;
    logic [1:0] ec;
    string tag;
    @(negedge clk);
    tag = predict(em, es, ec);
    n_chk++;
    if (issue_main !== em || issue_sec !== es || consume !== ec) begin
      n_fail++;
      $display("FAIL %s: main/sec/consume = %b/%b/%0d expected %b/%b/%0d",
               tag, issue_main, issue_sec, consume, em, es, ec);
    end
    // R9: structural relation between the outputs
    n_chk++;
    if ((issue_sec && !issue_main) || consume !== (2'(issue_main) + 2'(issue_sec))) begin
      n_fail++;
      $display("FAIL R9: main/sec/consume = %b/%b/%0d expected consistent count",
               issue_main, issue_sec, consume);
    end
    @(posedge clk);
  endtask

  // A clean pair that R8 accepts: distinct registers, all flags set.
  task automatic set_clean();
    stall = 0;
    i1_valid = 1; i1_simple = 1; i1_branch = 0; i1_has_dest = 1; i1_dest = 5'd3;
    i2_valid = 1; i2_simple = 1; i2_has_dest = 1; i2_dest = 5'd4;
    i2_src_use = 2'b11; i2_src = {5'd6, 5'd7};
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    set_clean(); i1_valid = 0; stall = 0;
    check_now();                                  // R1 idle
    set_clean(); check_now();                     // R8 clean pair
    set_clean(); stall = 1; check_now();          // R2 stall on a clean pair
    set_clean(); i2_valid = 0; i1_branch = 1; i1_simple = 0;
    i2_src = {5'd3, 5'd3}; check_now();           // R3 rules ignored
    set_clean(); i2_simple = 0; check_now();      // R4 trail complex
    set_clean(); i1_simple = 0; check_now();      // R4 lead complex
    set_clean(); i1_branch = 1; check_now();      // R5 branch lead
    set_clean(); i2_src = {5'd3, 5'd7}; check_now();          // R6 second source
    set_clean(); i2_src = {5'd6, 5'd3}; check_now();          // R6 first source
    set_clean(); i2_src = {5'd3, 5'd3}; i2_src_use = 2'b00;
    check_now();                                  // R6 unused sources ignored
    set_clean(); i2_src = {5'd3, 5'd7}; i1_has_dest = 0;
    i2_dest = 5'd3; check_now();                  // R6/R7 lead writes nothing
    set_clean(); i2_dest = 5'd3; check_now();     // R7 same destination
    set_clean(); i2_dest = 5'd3; i2_has_dest = 0; check_now(); // R7 gated
    set_clean(); i1_branch = 1; i2_dest = 5'd3; i2_src = {5'd3, 5'd3};
    check_now();                                  // R5 with every reason at once

    for (int n = 0; n < 3000; n++) begin
      stall       = ($urandom % 8) == 0;
      i1_valid    = ($urandom % 10) != 0;
      i1_simple   = ($urandom % 4) != 0;
      i1_branch   = ($urandom % 5) == 0;
      i1_has_dest = ($urandom % 4) != 0;
      i1_dest     = REG_W'($urandom % 4);
      i2_valid    = ($urandom % 6) != 0;
      i2_simple   = ($urandom % 4) != 0;
      i2_has_dest = ($urandom % 3) != 0;
      i2_dest     = REG_W'($urandom % 4);
      i2_src_use  = NUM_SRC'($urandom);
      for (int k = 0; k < NUM_SRC; k++)
        i2_src[k*REG_W +: REG_W] = REG_W'($urandom % 4);
      check_now();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule